// File: doc/BRIEF.md
# Page Write Buffer and Commit Engine

This block sits behind the byte-level front end of a two-wire serial memory. During a write transaction, each data byte that arrives is placed into a page buffer at the byte's offset within the page, and a valid flag is set for that slot. The buffer holds one page. The upstream front end wraps the offset inside the page, so a byte sent after the last slot lands on an early slot and replaces whatever was stored there.

Nothing reaches the array until the transaction ends with a stop event. At that stop the block launches a self-timed commit and raises busy for a programmable number of system clocks. During that window it walks the page slots in ascending order, one per clock, and issues one array write for each slot that was actually received. Slots that were not sent produce no write, so the array keeps their old contents. When the timer expires, all flags clear and busy drops.

A start event that arrives before the stop throws away the buffered bytes. A high write-protect input prevents every array write. While busy is high, every bus-side event is ignored.

Top module: `page_commit_engine`

## Requirements
- R1: Each accepted byte is stored at its 5-bit page offset in a 32-slot buffer; a later byte at the same offset replaces the earlier one, so bytes sent past the 32nd overwrite earlier slots of the same page.
- R2: A stop with at least one buffered byte and write-protect low raises busy on the clock after the stop, and keeps it high for exactly BUSY_CYC clocks (BUSY_CYC is raised internally to at least PAGE_BYTES+4).
- R3: The commit issues writes in ascending offset order, at most one per clock, only while busy is high; each write address is {row, offset}, with the row in the upper bits and the offset in the lower 5 bits. The row is the page row given with the last accepted byte.
- R4: Offsets not received in the transaction get no array write (partial page).
- R5: A stop with no buffered byte raises no busy and issues no write.
- R6: A start before the stop discards the buffered bytes. Only bytes accepted after that start can be committed.
- R7: While busy is high, byte strobes, start events and stop events are ignored. They neither alter the commit in progress nor leave anything buffered.
- R8: With write-protect high at the stop, no commit starts, busy stays low and the buffer is discarded. Write enable is never high on the clock after a clock with write-protect high.
- R9: When busy falls, all valid flags are clear, so the next transaction writes only its own bytes.
- R10: After reset, busy and the array write enable are low and no byte is buffered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_stb | input | 1 | One-clock strobe: a data byte was received |
| byte_off | input | 5 | Page offset of the received byte |
| byte_data | input | DATA_W | Received data byte |
| page_row | input | ROW_W | Page row of the current transaction |
| start_evt | input | 1 | One-clock pulse on a bus start event |
| stop_evt | input | 1 | One-clock pulse on a bus stop event |
| wp_in | input | 1 | Write-protect input, high blocks all array writes |
| arr_we | output | 1 | Array byte write enable |
| arr_addr | output | ROW_W+5 | Array byte address {row, offset} |
| arr_wdata | output | DATA_W | Array write data |
| busy | output | 1 | Commit in progress |

## Verification
The bench builds the block with ROW_W=3, BUSY_CYC=40 and the full 32-byte page. This keeps real wrap-around at the page edge, yet the timer ends only a few clocks after the slot walk. As a result, the exact busy length, the ordering of the writes and the flag clearing at expiry all fall within short runs. Upper row values are covered because the row field is small. A scoreboard model of the page predicts every array write from the stimulus alone. It also flags any write the model did not expect.

// File: rtl/pce_pkg.sv
package pce_pkg;

  typedef enum logic [1:0] {
    PCE_IDLE = 2'd0,
    PCE_WALK = 2'd1,
    PCE_WAIT = 2'd2
  } pce_state_e;

  function automatic int pce_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pce_page_ram.sv
module pce_page_ram #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DATA_W-1:0]        rdata
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/pce_valid_flags.sv
module pce_valid_flags #(
  parameter int DEPTH = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     set_en,
  input  logic [$clog2(DEPTH)-1:0] set_idx,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic                     any_o,
  output logic                     bit_o
);

  logic [DEPTH-1:0] flags_q;

  // a set in the same clock as a clear survives: the byte follows the clear
  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
    end else begin
      if (clr) flags_q <= '0;
      if (set_en) flags_q[set_idx] <= 1'b1;
    end
  end

  assign any_o = |flags_q;
  assign bit_o = flags_q[rd_idx];

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (clr && !set_en) |=> !any_o) else $error("flags not cleared"); // R9

endmodule

// File: rtl/pce_commit_seq.sv
module pce_commit_seq
  import pce_pkg::*;
#(
  parameter int PAGE_BYTES = 32,
  parameter int BUSY_CYC   = 500000
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start_evt,
  input  logic                          stop_evt,
  input  logic                          any_vld,
  input  logic                          wp_in,
  output logic                          busy_o,
  output logic                          accept_o,
  output logic                          discard_o,
  output logic                          flags_clr_o,
  output logic                          walk_act_o,
  output logic [$clog2(PAGE_BYTES)-1:0] walk_idx_o
);

  localparam int OFF_W   = $clog2(PAGE_BYTES);
  localparam int MIN_CYC = PAGE_BYTES + 4;
  localparam int EFF_CYC = pce_max(BUSY_CYC, MIN_CYC);
  localparam int TMR_W   = $clog2(EFF_CYC + 1);

  pce_state_e       state_q;
  logic [OFF_W-1:0] idx_q;
  logic [TMR_W-1:0] tmr_q;
  logic             launch;
  logic             expire;

  assign accept_o    = (state_q == PCE_IDLE);
  assign launch      = accept_o && stop_evt && any_vld && !wp_in;
  assign discard_o   = accept_o && (start_evt || (stop_evt && !launch));
  assign expire      = !accept_o && (tmr_q == TMR_W'(EFF_CYC - 1));
  assign flags_clr_o = expire;
  assign busy_o      = !accept_o;
  assign walk_act_o  = (state_q == PCE_WALK);
  assign walk_idx_o  = idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PCE_IDLE;
      idx_q   <= '0;
      tmr_q   <= '0;
    end else begin
      case (state_q)
        PCE_IDLE: begin
          if (launch) begin
            state_q <= PCE_WALK;
            idx_q   <= '0;
            tmr_q   <= '0;
          end
        end
        PCE_WALK: begin
          idx_q <= idx_q + 1'b1;
          tmr_q <= tmr_q + 1'b1;
          if (idx_q == OFF_W'(PAGE_BYTES - 1)) state_q <= PCE_WAIT;
        end
        PCE_WAIT: begin
          tmr_q <= tmr_q + 1'b1;
          if (expire) state_q <= PCE_IDLE;
        end
        default: state_q <= PCE_IDLE;
      endcase
    end
  end

  AST_BUSY_ON_STOP: assert property (@(posedge clk) disable iff (rst)
    (accept_o && stop_evt && any_vld && !wp_in) |=> busy_o) else $error("no busy after stop"); // R2
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> ($past(tmr_q) == TMR_W'(EFF_CYC - 1))) else $error("busy length"); // R2
  AST_NO_DATA_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
    (accept_o && stop_evt && !any_vld) |=> !busy_o) else $error("busy without data"); // R5
  AST_WP_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
    (accept_o && stop_evt && wp_in) |=> !busy_o) else $error("busy under protect"); // R8

endmodule

// File: rtl/page_commit_engine.sv
module page_commit_engine #(
  parameter int PAGE_BYTES = 32,
  parameter int ROW_W      = 8,
  parameter int DATA_W     = 8,
  parameter int BUSY_CYC   = 500000
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                byte_stb,
  input  logic [$clog2(PAGE_BYTES)-1:0]       byte_off,
  input  logic [DATA_W-1:0]                   byte_data,
  input  logic [ROW_W-1:0]                    page_row,
  input  logic                                start_evt,
  input  logic                                stop_evt,
  input  logic                                wp_in,
  output logic                                arr_we,
  output logic [ROW_W+$clog2(PAGE_BYTES)-1:0] arr_addr,
  output logic [DATA_W-1:0]                   arr_wdata,
  output logic                                busy
);

  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int ADDR_W = ROW_W + OFF_W;

  logic              accept, discard, flags_clr;
  logic              walk_act;
  logic [OFF_W-1:0]  walk_idx;
  logic              any_vld, slot_vld;
  logic              buf_we;
  logic [DATA_W-1:0] rd_data;
  logic [ROW_W-1:0]  row_q;
  logic              s1_vld_q;
  logic [OFF_W-1:0]  s1_off_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign buf_we = byte_stb && accept;

  pce_commit_seq #(
    .PAGE_BYTES (PAGE_BYTES),
    .BUSY_CYC   (BUSY_CYC)
  ) seq_i (
    .clk         (clk),
    .rst         (rst),
    .start_evt   (start_evt),
    .stop_evt    (stop_evt),
    .any_vld     (any_vld),
    .wp_in       (wp_in),
    .busy_o      (busy),
    .accept_o    (accept),
    .discard_o   (discard),
    .flags_clr_o (flags_clr),
    .walk_act_o  (walk_act),
    .walk_idx_o  (walk_idx)
  );

  pce_valid_flags #(
    .DEPTH (PAGE_BYTES)
  ) flags_i (
    .clk     (clk),
    .rst     (rst),
    .clr     (discard || flags_clr),
    .set_en  (buf_we),
    .set_idx (byte_off),
    .rd_idx  (walk_idx),
    .any_o   (any_vld),
    .bit_o   (slot_vld)
  );

  pce_page_ram #(
    .DEPTH  (PAGE_BYTES),
    .DATA_W (DATA_W)
  ) ram_i (
    .clk   (clk),
    .we    (buf_we),
    .waddr (byte_off),
    .wdata (byte_data),
    .re    (walk_act),
    .raddr (walk_idx),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) row_q <= '0;
    else if (buf_we) row_q <= page_row;
  end

  // stage 1 lines up the flag with the synchronous buffer read
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld_q <= 1'b0;
      s1_off_q <= '0;
    end else begin
      s1_vld_q <= walk_act && slot_vld;
      s1_off_q <= walk_idx;
    end
  end

  // stage 2 registers the array interface, protect gates every write
  always_ff @(posedge clk) begin
    if (rst) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      we_q    <= s1_vld_q && !wp_in;
      addr_q  <= {row_q, s1_off_q};
      wdata_q <= rd_data;
    end
  end

  assign arr_we    = we_q;
  assign arr_addr  = addr_q;
  assign arr_wdata = wdata_q;

  AST_WE_IN_COMMIT: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy) else $error("write outside commit"); // R3
  AST_WP_BLOCK: assert property (@(posedge clk) disable iff (rst)
    wp_in |=> !arr_we) else $error("write under protect"); // R8
  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && !flags_clr) |=> (any_vld == $past(any_vld))) else $error("flags moved while busy"); // R7
  AST_IDLE_EMPTY_AFTER: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !any_vld) else $error("flags left after commit"); // R9

endmodule

// File: tb/page_commit_engine_tb_top.sv
`timescale 1ns/1ps
module page_commit_engine_tb_top;

  localparam int PAGE_BYTES = 32;
  localparam int ROW_W      = 3;
  localparam int DATA_W     = 8;
  localparam int BUSY_CYC   = 40;
  localparam int OFF_W      = 5;
  localparam int ADDR_W     = ROW_W + OFF_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              byte_stb = 1'b0;
  logic [OFF_W-1:0]  byte_off = '0;
  logic [DATA_W-1:0] byte_data = '0;
  logic [ROW_W-1:0]  page_row = '0;
  logic              start_evt = 1'b0;
  logic              stop_evt = 1'b0;
  logic              wp_in = 1'b0;
  logic              arr_we;
  logic [ADDR_W-1:0] arr_addr;
  logic [DATA_W-1:0] arr_wdata;
  logic              busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [ADDR_W+DATA_W-1:0] exp_q[$];
  logic [DATA_W-1:0]        sh_data [PAGE_BYTES];
  bit                       sh_vld  [PAGE_BYTES];
  logic [ROW_W-1:0]         sh_row;

  always #2.5 clk = ~clk;

  page_commit_engine #(
    .PAGE_BYTES (PAGE_BYTES),
    .ROW_W      (ROW_W),
    .DATA_W     (DATA_W),
    .BUSY_CYC   (BUSY_CYC)
  ) dut_i (
    .clk       (clk),
    .rst       (rst),
    .byte_stb  (byte_stb),
    .byte_off  (byte_off),
    .byte_data (byte_data),
    .page_row  (page_row),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .wp_in     (wp_in),
    .arr_we    (arr_we),
    .arr_addr  (arr_addr),
    .arr_wdata (arr_wdata),
    .busy      (busy)
  );

  // monitor: every array write is popped from the scoreboard and compared
  always @(negedge clk) begin
    if (!rst && arr_we === 1'b1) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R4: unexpected write addr=%h data=%h, expected none", arr_addr, arr_wdata);
      end else begin
        logic [ADDR_W+DATA_W-1:0] e;
        e = exp_q.pop_front();
        if ({arr_addr, arr_wdata} !== e) begin
          errors++;
          $display("FAIL R3: write addr/data=%h/%h, expected %h/%h",
                   arr_addr, arr_wdata, e[ADDR_W+DATA_W-1:DATA_W], e[DATA_W-1:0]);
        end
      end
    end
  end

  task automatic shadow_clear();
    for (int i = 0; i < PAGE_BYTES; i++) sh_vld[i] = 1'b0;
  endtask

  task automatic send_byte(input int off, input logic [DATA_W-1:0] d, input logic [ROW_W-1:0] row);
    byte_stb  = 1'b1;
    byte_off  = OFF_W'(off);
    byte_data = d;
    page_row  = row;
    @(negedge clk);
    byte_stb  = 1'b0;
    sh_data[off] = d;
    sh_vld[off]  = 1'b1;
    sh_row       = row;
  endtask

  task automatic send_start();
    start_evt = 1'b1;
    @(negedge clk);
    start_evt = 1'b0;
    shadow_clear();
  endtask

  task automatic do_stop(input bit poke, input string tag);
    bit go;
    int cnt;
    go = 1'b0;
    for (int i = 0; i < PAGE_BYTES; i++) if (sh_vld[i]) go = 1'b1;
    if (wp_in) go = 1'b0;
    if (go) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (sh_vld[i]) exp_q.push_back({sh_row, OFF_W'(i), sh_data[i]});
    end
    shadow_clear();
    stop_evt = 1'b1;
    @(negedge clk);
    stop_evt = 1'b0;
    checks++;
    if (busy !== go) begin
      errors++;
      $display("FAIL %s: busy after stop=%b, expected %b", tag, busy, go);
    end
    if (go) begin
      cnt = 0;
      while (busy === 1'b1 && cnt < 1000) begin
        cnt++;
        if (poke) begin
          // R7: a byte, a start and a stop while busy, all to be ignored
          if (cnt == 3) begin byte_stb = 1'b1; byte_off = 5'd7; byte_data = 8'hEE; end
          if (cnt == 4) begin byte_stb = 1'b0; start_evt = 1'b1; end
          if (cnt == 5) begin start_evt = 1'b0; stop_evt = 1'b1; end
          if (cnt == 6) stop_evt = 1'b0;
        end
        @(negedge clk);
      end
      checks++;
      if (cnt != BUSY_CYC) begin
        errors++;
        $display("FAIL R2: busy lasted %0d clocks, expected %0d", cnt, BUSY_CYC);
      end
    end else begin
      repeat (3) @(negedge clk);
      checks++;
      if (busy !== 1'b0) begin
        errors++;
        $display("FAIL %s: busy later=%b, expected 0", tag, busy);
      end
    end
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R4: %0d expected writes missing, expected 0", exp_q.size());
      exp_q.delete();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    shadow_clear();
    sh_row = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R10: reset state
    checks++;
    if (busy !== 1'b0 || arr_we !== 1'b0) begin
      errors++;
      $display("FAIL R10: busy=%b we=%b, expected 0 0", busy, arr_we);
    end
    do_stop(1'b0, "R10");

    // R1 R2 R3: contiguous bytes
    for (int i = 0; i < 4; i++) send_byte(i, 8'h10 + 8'(i), 3'd2);
    do_stop(1'b0, "R2");

    // R3 R4: scattered partial page, received out of order, upper row
    send_byte(31, 8'hA1, 3'd7);
    send_byte(10, 8'hB2, 3'd7);
    send_byte(4,  8'hC3, 3'd7);
    do_stop(1'b0, "R3");

    // R1: 40 bytes wrap inside the page and overwrite earlier slots
    for (int i = 0; i < 40; i++) send_byte((20 + i) % PAGE_BYTES, 8'(i * 3 + 1), 3'd5);
    do_stop(1'b0, "R1");

    // R5: address-only transaction
    send_start();
    do_stop(1'b0, "R5");

    // R6: start before stop discards
    send_byte(1, 8'h55, 3'd1);
    send_byte(2, 8'h66, 3'd1);
    send_start();
    do_stop(1'b0, "R6");
    send_byte(1, 8'h77, 3'd1);
    send_byte(2, 8'h88, 3'd1);
    send_start();
    send_byte(9, 8'h99, 3'd3);
    do_stop(1'b0, "R6");

    // R7: bus events during busy are ignored, nothing is left buffered
    send_byte(0, 8'h01, 3'd4);
    send_byte(7, 8'h07, 3'd4);
    do_stop(1'b1, "R7");
    do_stop(1'b0, "R7");

    // R9: stale slots from a previous commit are not written again
    for (int i = 0; i < 6; i++) send_byte(i, 8'hD0 + 8'(i), 3'd6);
    do_stop(1'b0, "R9");
    send_byte(3, 8'h3C, 3'd6);
    do_stop(1'b0, "R9");

    // R8: protect high at stop blocks the commit and drops the buffer
    wp_in = 1'b1;
    send_byte(5, 8'h5A, 3'd0);
    send_byte(6, 8'h6B, 3'd0);
    do_stop(1'b0, "R8");
    wp_in = 1'b0;
    @(negedge clk);
    do_stop(1'b0, "R8");
    send_byte(12, 8'hC4, 3'd0);
    do_stop(1'b0, "R8");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule